// File: doc/BRIEF.md
# Dual-Mode Scan Rate Scheduler

This block paces the conversions of a four-channel sensing core. Running from the core's free-running reference clock, it issues a one-cycle scan-start strobe together with the set of channels that scan must cover. The core answers each strobe with a one-cycle done pulse. The scheduler starts no new scan until that done pulse has arrived.

Two operating modes are supported. Normal mode offers four scan rates, plus a fast override and a continuous override. In continuous mode each scan begins as soon as the previous one has finished. Low-power mode offers four slower rates and uses a narrower channel set. A configuration hold input stops all scans while the register values stay untouched.

Every interval is a power-of-two multiple of one base period of `BASE_TICKS` reference cycles. The base period is the fastest rate, 160 samples per second. The selected interval and channel set are captured at each strobe, so a new setting applies only from the next scan boundary.

Top module: `scan_rate_sched`

## Requirements
- R1: While `rst_n` is low, `scan_start_o` is 0 and `scan_mask_o` is all ones. The first strobe after reset appears in the first cycle after the first clock edge with `rst_n` high.
- R2: In normal mode with both overrides clear, a strobe-to-strobe interval of 2, 4, 8 or 16 times `BASE_TICKS` cycles is produced by `np_rate_i` codes 0, 1, 2 and 3. These intervals correspond to 80, 40, 20 and 10 samples per second.
- R3: In normal mode, `np_fast_i`=1 sets the interval to `BASE_TICKS` cycles (160 samples per second), whatever the value of `np_rate_i`.
- R4: In normal mode, `np_cont_i`=1 overrides both `np_fast_i` and `np_rate_i`. The next strobe then appears two cycles after the cycle in which `scan_done_i` is high.
- R5: In low-power mode (`low_power_i`=1), an interval of 32, 64, 128 or 256 times `BASE_TICKS` is produced by `lp_rate_i` codes 0 to 3. These intervals correspond to 5, 2.5, 1.25 and 0.625 samples per second. `np_cont_i` and `np_fast_i` have no effect in this mode.
- R6: Bit i of `scan_mask_o` stands for channel i. At a strobe the mask is `ch_en_i` in normal mode and `ch_en_i & ch_lpen_i` in low-power mode. It is captured at the strobe and holds its value until the next strobe.
- R7: While `cfg_hold_i` is 1, no strobe is issued and the settings are kept. After `cfg_hold_i` falls, a strobe appears one cycle later, and the following intervals follow the settings in place.
- R8: No strobe is issued while a done pulse is outstanding. With done latency L cycles after the strobe and period P, the next strobe comes max(P, L+2) cycles after the previous one.
- R9: A change of rate or mode made between strobes leaves the interval in progress unchanged. The new interval applies from the next strobe on.
- R10: If the selected channel set is empty, no strobe is issued. Once a channel becomes selected and the interval has elapsed, a strobe appears one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running reference clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| low_power_i | input | 1 | 1 selects low-power mode |
| np_rate_i | input | 2 | Normal-mode rate code |
| np_fast_i | input | 1 | Normal-mode fast override |
| np_cont_i | input | 1 | Normal-mode continuous override |
| lp_rate_i | input | 2 | Low-power rate code |
| ch_en_i | input | NUM_CH | Per-channel enable |
| ch_lpen_i | input | NUM_CH | Per-channel low-power enable |
| cfg_hold_i | input | 1 | Configuration hold; blocks all scans |
| scan_done_i | input | 1 | One-cycle completion pulse from the core |
| scan_start_o | output | 1 | One-cycle scan-start strobe |
| scan_mask_o | output | NUM_CH | Channels covered by the current scan |

## Verification
The bench builds the scheduler with `BASE_TICKS`=2 and four channels. At that setting the base period is two cycles and the slowest low-power interval is 512 cycles, so every rate code, both overrides and both modes can be timed exactly within a short run. The short base period also allows a done latency longer than the fast period. That case tests the max(P, L+2) rule and shows whether the outstanding-done check actually delays the next strobe.

// File: rtl/scan_sched_pkg.sv
package scan_sched_pkg;

  // Interval = BASE_TICKS << shift; shift 0 is the fastest rate.
  localparam int unsigned SHIFT_W       = 4;
  localparam int unsigned MAX_SHIFT     = 8;
  localparam logic [SHIFT_W-1:0] NP_SHIFT0     = 4'd1;
  localparam logic [SHIFT_W-1:0] LP_SHIFT0     = 4'd5;
  localparam logic [SHIFT_W-1:0] DEFAULT_SHIFT = 4'd2;

  typedef struct packed {
    logic               cont;
    logic [SHIFT_W-1:0] shift;
  } rate_sel_t;

  // Override priority: low-power mode, then fast, then the normal code.
  function automatic logic [SHIFT_W-1:0] pick_shift(input logic       lp,
                                                    input logic       fast,
                                                    input logic [1:0] np_code,
                                                    input logic [1:0] lp_code);
    if (lp)        return LP_SHIFT0 + {2'b00, lp_code};
    else if (fast) return '0;
    else           return NP_SHIFT0 + {2'b00, np_code};
  endfunction

  // Continuous scanning applies to normal mode only.
  function automatic logic pick_cont(input logic lp, input logic cont);
    return cont & ~lp;
  endfunction

endpackage

// File: rtl/rate_select.sv
module rate_select
  import scan_sched_pkg::*;
(
  input  logic       lp_mode_i,
  input  logic [1:0] np_code_i,
  input  logic       np_fast_i,
  input  logic       np_cont_i,
  input  logic [1:0] lp_code_i,
  output rate_sel_t  sel_o
);

  always_comb begin
    sel_o.shift = pick_shift(lp_mode_i, np_fast_i, np_code_i, lp_code_i);
    sel_o.cont  = pick_cont(lp_mode_i, np_cont_i);
  end

endmodule

// File: rtl/interval_timer.sv
module interval_timer
  import scan_sched_pkg::*;
#(
  parameter int unsigned BASE_TICKS = 6250,
  localparam int unsigned LONGEST   = BASE_TICKS * (2 ** MAX_SHIFT),
  localparam int unsigned CNT_W     = $clog2(LONGEST + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               hold_i,
  input  logic               restart_i,
  input  logic [SHIFT_W-1:0] next_shift_i,
  output logic               due_o
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0]   cnt_q;
  logic [SHIFT_W-1:0] shift_q;
  logic [CNT_W-1:0]   period;

  // Interval latched at the strobe; a later change waits for the next boundary.
  assign period = CNT_W'(BASE_TICKS) << shift_q;
  assign due_o  = (cnt_q >= period);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= CNT_MAX;
      shift_q <= DEFAULT_SHIFT;
    end else begin
      if (restart_i) shift_q <= next_shift_i;
      if (hold_i)                cnt_q <= CNT_MAX;
      else if (restart_i)        cnt_q <= CNT_W'(1);
      else if (cnt_q != CNT_MAX) cnt_q <= cnt_q + CNT_W'(1);
    end
  end

  AST_CNT_SATURATES: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold_i && !restart_i && cnt_q == CNT_MAX) |=> cnt_q == CNT_MAX); // R10

  AST_RESTART_LOADS_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (restart_i && !hold_i) |=> cnt_q == CNT_W'(1)); // R9

endmodule

// File: rtl/channel_mask.sv
module channel_mask #(
  parameter int unsigned NUM_CH = 4
) (
  input  logic              lp_mode_i,
  input  logic [NUM_CH-1:0] en_i,
  input  logic [NUM_CH-1:0] lpen_i,
  output logic [NUM_CH-1:0] mask_o,
  output logic              any_o
);

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    assign mask_o[i] = en_i[i] & (lp_mode_i ? lpen_i[i] : 1'b1);
  end

  assign any_o = |mask_o;

endmodule

// File: rtl/scan_rate_sched.sv
module scan_rate_sched
  import scan_sched_pkg::*;
#(
  parameter int unsigned NUM_CH     = 4,
  parameter int unsigned BASE_TICKS = 6250
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              low_power_i,
  input  logic [1:0]        np_rate_i,
  input  logic              np_fast_i,
  input  logic              np_cont_i,
  input  logic [1:0]        lp_rate_i,
  input  logic [NUM_CH-1:0] ch_en_i,
  input  logic [NUM_CH-1:0] ch_lpen_i,
  input  logic              cfg_hold_i,
  input  logic              scan_done_i,
  output logic              scan_start_o,
  output logic [NUM_CH-1:0] scan_mask_o
);

  localparam logic [NUM_CH-1:0] RESET_MASK = '1;

  rate_sel_t         sel;
  logic [NUM_CH-1:0] next_mask;
  logic              mask_any;
  logic              due;
  logic              ready;
  logic              fire;
  logic              busy_q;
  logic              cont_q;
  logic              start_q;
  logic [NUM_CH-1:0] mask_q;

  rate_select i_rate_select (
    .lp_mode_i (low_power_i),
    .np_code_i (np_rate_i),
    .np_fast_i (np_fast_i),
    .np_cont_i (np_cont_i),
    .lp_code_i (lp_rate_i),
    .sel_o     (sel)
  );

  channel_mask #(.NUM_CH(NUM_CH)) i_channel_mask (
    .lp_mode_i (low_power_i),
    .en_i      (ch_en_i),
    .lpen_i    (ch_lpen_i),
    .mask_o    (next_mask),
    .any_o     (mask_any)
  );

  interval_timer #(.BASE_TICKS(BASE_TICKS)) i_interval_timer (
    .clk          (clk),
    .rst_n        (rst_n),
    .hold_i       (cfg_hold_i),
    .restart_i    (fire),
    .next_shift_i (sel.shift),
    .due_o        (due)
  );

  // Continuous scans wait only for the done pulse; timed ones also for the interval.
  assign ready = cont_q | due;
  assign fire  = !cfg_hold_i && !busy_q && mask_any && ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      cont_q  <= 1'b0;
      start_q <= 1'b0;
      mask_q  <= RESET_MASK;
    end else begin
      start_q <= fire;
      if (fire) begin
        busy_q <= 1'b1;
        cont_q <= sel.cont;
        mask_q <= next_mask;
      end else if (scan_done_i) begin
        busy_q <= 1'b0;
      end
    end
  end

  assign scan_start_o = start_q;
  assign scan_mask_o  = mask_q;

  AST_HOLD_BLOCKS_START: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_hold_i |=> !scan_start_o); // R7

  AST_NO_BACK_TO_BACK: assert property (@(posedge clk) disable iff (!rst_n)
    scan_start_o |=> !scan_start_o); // R8

  AST_MASK_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    scan_start_o |-> (scan_mask_o != '0)); // R10

  AST_MASK_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !scan_start_o |-> $stable(scan_mask_o)); // R6

  AST_LP_MASK_SUBSET: assert property (@(posedge clk) disable iff (!rst_n)
    (scan_start_o && $past(low_power_i)) |-> ((scan_mask_o & ~$past(ch_lpen_i)) == '0)); // R6

endmodule

// File: tb/test_scan_rate_sched.sv
`timescale 1ns/1ps
module test_scan_rate_sched;

  localparam int unsigned NUM_CH = 4;
  localparam int unsigned BASE   = 2;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              low_power_i = 1'b0;
  logic [1:0]        np_rate_i = 2'd1;
  logic              np_fast_i = 1'b0;
  logic              np_cont_i = 1'b0;
  logic [1:0]        lp_rate_i = 2'd2;
  logic [NUM_CH-1:0] ch_en_i = 4'hF;
  logic [NUM_CH-1:0] ch_lpen_i = 4'h1;
  logic              cfg_hold_i = 1'b0;
  logic              scan_done_i = 1'b0;
  logic              scan_start_o;
  logic [NUM_CH-1:0] scan_mask_o;

  int checks = 0;
  int errors = 0;
  bit auto_done = 1'b1;
  int done_lat = 0;

  always #5 clk = ~clk;

  scan_rate_sched #(.NUM_CH(NUM_CH), .BASE_TICKS(BASE)) i_scan_rate_sched (
    .clk          (clk),
    .rst_n        (rst_n),
    .low_power_i  (low_power_i),
    .np_rate_i    (np_rate_i),
    .np_fast_i    (np_fast_i),
    .np_cont_i    (np_cont_i),
    .lp_rate_i    (lp_rate_i),
    .ch_en_i      (ch_en_i),
    .ch_lpen_i    (ch_lpen_i),
    .cfg_hold_i   (cfg_hold_i),
    .scan_done_i  (scan_done_i),
    .scan_start_o (scan_start_o),
    .scan_mask_o  (scan_mask_o)
  );

  // Core model: answers each strobe with a done pulse after done_lat cycles.
  initial begin
    forever begin
      @(negedge clk);
      if (scan_start_o && auto_done) begin
        repeat (done_lat) @(negedge clk);
        scan_done_i = 1'b1;
        @(negedge clk);
        scan_done_i = 1'b0;
      end
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Counts negedges until the next strobe; -1 on timeout.
  task automatic wait_start(output int waited);
    waited = -1;
    for (int n = 1; n <= 2000; n++) begin
      @(negedge clk);
      if (scan_start_o) begin
        waited = n;
        break;
      end
    end
  endtask

  // Syncs to the boundary that latches the current settings, then times one interval.
  task automatic gap_after_sync(output int gap);
    int dummy;
    wait_start(dummy);
    wait_start(gap);
  endtask

  task automatic t_reset();
    int w;
    repeat (3) @(negedge clk);
    chk("R1 start in reset", int'(scan_start_o), 0);
    chk("R1 mask in reset", int'(scan_mask_o), 15);
    rst_n = 1'b1;
    wait_start(w);
    chk("R1 first strobe delay", w, 1);
    chk("R1 first mask", int'(scan_mask_o), 15);
  endtask

  task automatic t_np_rates();
    int g;
    for (int c = 0; c < 4; c++) begin
      np_rate_i = 2'(c);
      gap_after_sync(g);
      chk("R2 normal rate interval", g, int'(BASE) << (c + 1));
    end
  endtask

  task automatic t_fast();
    int g;
    np_rate_i = 2'd3;
    np_fast_i = 1'b1;
    gap_after_sync(g);
    chk("R3 fast interval", g, int'(BASE));
    np_fast_i = 1'b0;
  endtask

  task automatic t_cont();
    int g;
    np_rate_i = 2'd3;
    np_fast_i = 1'b1;
    np_cont_i = 1'b1;
    done_lat  = 0;
    gap_after_sync(g);
    chk("R4 continuous latency 0", g, 2);
    done_lat = 3;
    gap_after_sync(g);
    chk("R4 continuous latency 3", g, 5);
    done_lat  = 0;
    np_cont_i = 1'b0;
    np_fast_i = 1'b0;
  endtask

  task automatic t_lp();
    int g;
    np_cont_i   = 1'b1;
    np_fast_i   = 1'b1;
    ch_en_i     = 4'b1011;
    ch_lpen_i   = 4'b0110;
    low_power_i = 1'b1;
    for (int c = 0; c < 4; c++) begin
      lp_rate_i = 2'(c);
      gap_after_sync(g);
      chk("R5 low-power interval", g, int'(BASE) << (c + 5));
    end
    chk("R6 low-power mask", int'(scan_mask_o), 4'b0010);
    low_power_i = 1'b0;
    np_cont_i   = 1'b0;
    np_fast_i   = 1'b0;
  endtask

  task automatic t_mask_np();
    int w;
    np_rate_i = 2'd0;
    ch_en_i   = 4'b1010;
    ch_lpen_i = 4'b0101;
    wait_start(w);
    chk("R6 normal mask", int'(scan_mask_o), 4'b1010);
    ch_en_i = 4'b0001;
    @(negedge clk);
    chk("R6 mask held between strobes", int'(scan_mask_o), 4'b1010);
    wait_start(w);
    chk("R6 mask at next strobe", int'(scan_mask_o), 4'b0001);
    ch_en_i = 4'hF;
  endtask

  task automatic t_late_done();
    int g;
    np_fast_i = 1'b1;
    done_lat  = 5;
    gap_after_sync(g);
    chk("R8 late done delays strobe", g, 7);
    done_lat  = 0;
    np_fast_i = 1'b0;
  endtask

  task automatic t_boundary();
    int w, g;
    np_rate_i = 2'd3;
    wait_start(w);
    wait_start(w);
    repeat (3) @(negedge clk);
    np_rate_i = 2'd0;
    wait_start(g);
    chk("R9 interval in progress kept", g, 16 * int'(BASE) - 3);
    wait_start(g);
    chk("R9 new interval after boundary", g, 2 * int'(BASE));
  endtask

  task automatic t_hold();
    int seen, w, g;
    np_rate_i  = 2'd2;
    cfg_hold_i = 1'b1;
    seen = 0;
    @(negedge clk);
    for (int n = 0; n < 600; n++) begin
      @(negedge clk);
      if (scan_start_o) seen++;
    end
    chk("R7 no strobe while held", seen, 0);
    cfg_hold_i = 1'b0;
    wait_start(w);
    chk("R7 strobe after release", w, 1);
    wait_start(g);
    chk("R7 settings kept through hold", g, 8 * int'(BASE));
  endtask

  task automatic t_empty();
    int seen, w;
    low_power_i = 1'b0;
    ch_en_i = 4'b0000;
    seen = 0;
    for (int n = 0; n < 200; n++) begin
      @(negedge clk);
      if (scan_start_o) seen++;
    end
    chk("R10 no strobe with empty set", seen, 0);
    ch_en_i = 4'b0100;
    wait_start(w);
    chk("R10 strobe after channel enabled", w, 1);
    chk("R10 mask after resume", int'(scan_mask_o), 4'b0100);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_np_rates();
    t_fast();
    t_cont();
    t_lp();
    t_mask_np();
    t_late_done();
    t_boundary();
    t_hold();
    t_empty();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule